// File: doc/BRIEF.md
# Page-Buffered Write Sequencer with Word Address Counter

This block sits between a two-wire serial protocol engine and a byte-wide array of 512 words. It owns the 9-bit word address counter. The engine hands it one-cycle strobes: load an address, write a byte, read a byte, and end of transaction (STOP). Written bytes do not go straight to the array. They are gathered in a 16-entry page buffer, and a per-entry valid mask records which entries the current transaction wrote.

When a STOP closes a write transaction that delivered at least one byte, the sequencer copies the marked entries into the array. It does this inside a self-timed write cycle of `WR_CYCLES` clocks. Throughout that cycle `busy_o` is high and every strobe is dropped. The serial engine uses `busy_o` to withhold its acknowledge while the write cycle runs.

If write protect is high when the STOP arrives, the buffered bytes are thrown away. In that case there is no write cycle and no busy period. Reads step the counter across the whole array. Writes step only the offset within a page, so a long write burst stays inside its page. The counter keeps its value between transactions, so a read that follows without a fresh address load continues from where the last access stopped.

Top module: `page_write_seq`

## Requirements
- R1: After reset `busy_o` is 0, `cur_addr_o` is 0 and `rd_data_o` is 0.
- R2: A `ld_addr_i` strobe accepted while not busy sets `cur_addr_o` to `addr_i` one cycle later and empties the page buffer.
- R3: An accepted `rd_byte_i` strobe presents the array byte at the current address on `rd_data_o` one cycle later. The counter advances by one, and address 511 is followed by address 0.
- R4: An accepted `wr_byte_i` strobe advances only bits 3:0 of the counter, so offset 15 is followed by offset 0. Bits 8:4 (the page row) do not change.
- R5: A STOP after one or more written bytes, with write protect low, writes to the array only the page entries written in that transaction. All other bytes of the page keep their old values. A partial page is allowed.
- R6: If more than 16 bytes arrive in one transaction, a later byte replaces the earlier byte at the same wrapped offset.
- R7: A committing STOP raises `busy_o` in the next cycle. `busy_o` then stays high for exactly `WR_CYCLES` consecutive cycles.
- R8: While `busy_o` is high, all four strobes are ignored. The address counter, `rd_data_o` and the buffer contents do not change.
- R9: With `wp_i` high at STOP, the buffered bytes are discarded. `busy_o` stays low and the array is unchanged.
- R10: A STOP that ends a read, or a write that carried no data bytes, starts no write cycle.
- R11: Between transactions the counter holds the last accessed address plus one, following the wrap rule of that access. A read issued without a new address load starts there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wp_i | input | 1 | Write protect, sampled when STOP is accepted |
| ld_addr_i | input | 1 | Strobe: load word address |
| addr_i | input | ADDR_W | Word address to load |
| wr_byte_i | input | 1 | Strobe: one data byte received |
| wr_data_i | input | DATA_W | Received data byte |
| rd_byte_i | input | 1 | Strobe: fetch next byte for transmission |
| stop_i | input | 1 | Strobe: transaction ended by STOP |
| rd_data_o | output | DATA_W | Byte fetched by the last read strobe |
| busy_o | output | 1 | Internal write cycle in progress |
| cur_addr_o | output | ADDR_W | Current word address counter |

## Verification
The assertions assume that at most one strobe is high in any cycle, as a serial engine produces them. They also assume that `WR_CYCLES` is at least the page size, so the commit walk always ends inside the busy window. The stimulus keeps to both assumptions. Every strobe lasts exactly one cycle and only one is raised at a time. This holds even during the busy window, where ld, wr, rd and STOP are injected one after another to probe R8. The default `WR_CYCLES` of 40 is comfortably above the 16-entry walk.

// File: rtl/wseq_pkg.sv
package wseq_pkg;

  // Advance the offset inside a page of 2**pw bytes; the row bits stay.
  function automatic logic [31:0] step_in_page(logic [31:0] a, int unsigned pw);
    logic [31:0] m;
    m = (32'd1 << pw) - 32'd1;
    return (a & ~m) | ((a + 32'd1) & m);
  endfunction

  // Advance across an array of 2**aw bytes, wrapping to zero.
  function automatic logic [31:0] step_linear(logic [31:0] a, int unsigned aw);
    return (a + 32'd1) & ((32'd1 << aw) - 32'd1);
  endfunction

endpackage

// File: rtl/wseq_addr_ctr.sv
module wseq_addr_ctr #(
  parameter int ADDR_W = 9,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step_pg,
  input  logic              step_lin,
  output logic [ADDR_W-1:0] addr_q
);
  logic [ADDR_W-1:0] pg_next;
  logic [ADDR_W-1:0] lin_next;

  assign pg_next  = ADDR_W'(wseq_pkg::step_in_page(32'(addr_q), PAGE_W));
  assign lin_next = ADDR_W'(wseq_pkg::step_linear(32'(addr_q), ADDR_W));

  always_ff @(posedge clk) begin
    if (!rst_n)        addr_q <= '0;
    else if (load)     addr_q <= load_val;
    else if (step_pg)  addr_q <= pg_next;
    else if (step_lin) addr_q <= lin_next;
  end
endmodule

// File: rtl/wseq_page_buf.sv
module wseq_page_buf #(
  parameter int DATA_W = 8,
  parameter int PAGE_W = 4,
  parameter int ROW_W  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    wr,
  input  logic [PAGE_W-1:0]       wr_idx,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic [ROW_W-1:0]        wr_row,
  input  logic                    start,
  output logic                    has_data,
  output logic                    committing,
  output logic                    mem_we,
  output logic [ROW_W+PAGE_W-1:0] mem_addr,
  output logic [DATA_W-1:0]       mem_wdata
);
  localparam int N = 1 << PAGE_W;

  logic [DATA_W-1:0] bytes_q [N];
  logic [N-1:0]      valid_q;
  logic [ROW_W-1:0]  row_q;
  logic [PAGE_W-1:0] idx_q;
  logic              run_q;

  for (genvar g = 0; g < N; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (wr && wr_idx == PAGE_W'(g)) bytes_q[g] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      row_q   <= '0;
      idx_q   <= '0;
      run_q   <= 1'b0;
    end else begin
      if (clear) begin
        valid_q <= '0;
      end else if (wr) begin
        valid_q[wr_idx] <= 1'b1;
        row_q           <= wr_row;
      end else if (run_q) begin
        valid_q[idx_q] <= 1'b0;
      end
      if (start) begin
        run_q <= 1'b1;
        idx_q <= '0;
      end else if (run_q) begin
        idx_q <= idx_q + PAGE_W'(1);
        if (&idx_q) run_q <= 1'b0;
      end
    end
  end

  assign has_data   = |valid_q;
  assign committing = run_q;
  assign mem_we     = run_q & valid_q[idx_q];
  assign mem_addr   = {row_q, idx_q};
  assign mem_wdata  = bytes_q[idx_q];
endmodule

// File: rtl/wseq_wr_timer.sv
module wseq_wr_timer #(
  parameter int CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      left_q <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      left_q <= CW'(CYC - 1);
    end else if (busy) begin
      if (left_q == '0) busy <= 1'b0;
      else              left_q <= left_q - CW'(1);
    end
  end
endmodule

// File: rtl/wseq_array.sv
module wseq_array #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/page_write_seq.sv
module page_write_seq #(
  parameter int ADDR_W    = 9,
  parameter int PAGE_W    = 4,
  parameter int DATA_W    = 8,
  parameter int WR_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_i,
  input  logic              ld_addr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_byte_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_byte_i,
  input  logic              stop_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] cur_addr_o
);
  localparam int ROW_W = ADDR_W - PAGE_W;

  // Named internal events, visible to the bound checker.
  logic accept_ld, accept_wr, accept_rd, accept_stop;
  logic start_commit, discard, buf_clear;
  logic has_data, committing, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;

  assign accept_ld    = ld_addr_i & ~busy_o;
  assign accept_wr    = wr_byte_i & ~busy_o & ~ld_addr_i;
  assign accept_rd    = rd_byte_i & ~busy_o & ~ld_addr_i & ~wr_byte_i;
  assign accept_stop  = stop_i & ~busy_o;
  assign start_commit = accept_stop & has_data & ~wp_i;
  assign discard      = accept_stop & ~start_commit;
  assign buf_clear    = accept_ld | discard;

  wseq_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
    .clk(clk), .rst_n(rst_n),
    .load(accept_ld), .load_val(addr_i),
    .step_pg(accept_wr), .step_lin(accept_rd),
    .addr_q(cur_addr_o)
  );

  wseq_page_buf #(.DATA_W(DATA_W), .PAGE_W(PAGE_W), .ROW_W(ROW_W)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .clear(buf_clear), .wr(accept_wr),
    .wr_idx(cur_addr_o[PAGE_W-1:0]), .wr_data(wr_data_i),
    .wr_row(cur_addr_o[ADDR_W-1:PAGE_W]),
    .start(start_commit),
    .has_data(has_data), .committing(committing),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  wseq_wr_timer #(.CYC(WR_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(start_commit), .busy(busy_o)
  );

  wseq_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata),
    .re(accept_rd), .raddr(cur_addr_o), .rdata(rd_data_o)
  );
endmodule

// File: rtl/wseq_checker.sv
module wseq_checker #(
  parameter int ADDR_W    = 9,
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              wp_i,
  input logic [ADDR_W-1:0] cur_addr_o,
  input logic [ADDR_W-1:0] addr_i,
  input logic              accept_ld,
  input logic              accept_wr,
  input logic              accept_rd,
  input logic              accept_stop,
  input logic              start_commit,
  input logic              has_data,
  input logic              mem_we
);
  localparam logic [PAGE_W-1:0] ONE_P = 1;
  localparam logic [ADDR_W-1:0] ONE_A = 1;

  int run_q;
  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= 0;
    else        run_q <= busy_o ? run_q + 1 : 0;
  end

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ld |=> cur_addr_o == $past(addr_i));

  assert_lin_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept_rd |=> cur_addr_o == $past(cur_addr_o) + ONE_A);

  assert_page_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept_wr |=> (cur_addr_o[ADDR_W-1:PAGE_W] == $past(cur_addr_o[ADDR_W-1:PAGE_W]))
               && (cur_addr_o[PAGE_W-1:0] == $past(cur_addr_o[PAGE_W-1:0]) + ONE_P));

  assert_commit_in_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy_o);

  assert_busy_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_commit |=> busy_o);

  assert_busy_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> run_q == WR_CYCLES);

  assert_busy_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> run_q < WR_CYCLES);

  assert_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(cur_addr_o));

  assert_wp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_stop && wp_i) |=> !busy_o);

  assert_empty_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_stop && !has_data) |=> !busy_o);
endmodule

bind page_write_seq wseq_checker #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .wp_i(wp_i),
  .cur_addr_o(cur_addr_o), .addr_i(addr_i),
  .accept_ld(accept_ld), .accept_wr(accept_wr), .accept_rd(accept_rd),
  .accept_stop(accept_stop), .start_commit(start_commit),
  .has_data(has_data), .mem_we(mem_we)
);

// File: tb/sim_page_write_seq.sv
module sim_page_write_seq;
  localparam int AW = 9;
  localparam int DW = 8;
  localparam int CYC = 40;
  localparam int NWORDS = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wp = 1'b0, ld = 1'b0, wr = 1'b0, rd = 1'b0, stp = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic busy;
  logic [AW-1:0] caddr;

  always #5 clk = ~clk;

  page_write_seq #(.ADDR_W(AW), .PAGE_W(4), .DATA_W(DW), .WR_CYCLES(CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .wp_i(wp), .ld_addr_i(ld), .addr_i(addr),
    .wr_byte_i(wr), .wr_data_i(wdata), .rd_byte_i(rd), .stop_i(stp),
    .rd_data_o(rdata), .busy_o(busy), .cur_addr_o(caddr)
  );

  int checks = 0;
  int errors = 0;

  // Reference state, computed from the requirements.
  logic [7:0] model [NWORDS];
  int maddr = 0;
  logic [7:0] stage [16];
  logic [15:0] smask = '0;
  int srow = 0;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 29 + (a >> 3) + 7) % 256);
  endfunction

  task automatic do_ld(input int a);
    ld = 1'b1; addr = 9'(a);
    @(negedge clk);
    ld = 1'b0;
    maddr = a; smask = '0;
    check("R2 load address", int'(caddr), a);
  endtask

  task automatic do_wr(input logic [7:0] d);
    wr = 1'b1; wdata = d;
    @(negedge clk);
    wr = 1'b0;
    stage[maddr % 16] = d;
    smask[maddr % 16] = 1'b1;
    srow = maddr / 16;
    maddr = (maddr / 16) * 16 + ((maddr % 16) + 1) % 16;
    check("R4 page-local step", int'(caddr), maddr);
  endtask

  task automatic do_rd(input string tag);
    int exp;
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    exp = int'(model[maddr]);
    maddr = (maddr + 1) % NWORDS;
    check({tag, " read data"}, int'(rdata), exp);
    check("R3 read step", int'(caddr), maddr);
  endtask

  task automatic do_stop(input bit inject, input string quiet_tag);
    bit exp_busy;
    int n;
    logic [AW-1:0] a0;
    logic [DW-1:0] d0;
    exp_busy = (smask != 16'h0) && !wp;
    stp = 1'b1;
    @(negedge clk);
    stp = 1'b0;
    if (exp_busy) begin
      for (int i = 0; i < 16; i++)
        if (smask[i]) model[srow * 16 + i] = stage[i];
      check("R7 busy rises", int'(busy), 1);
      a0 = caddr; d0 = rdata; n = 1;
      if (inject) begin
        ld = 1'b1; addr = ~a0;
        @(negedge clk); ld = 1'b0; n += int'(busy);
        wr = 1'b1; wdata = 8'hEE;
        @(negedge clk); wr = 1'b0; n += int'(busy);
        rd = 1'b1;
        @(negedge clk); rd = 1'b0; n += int'(busy);
        stp = 1'b1;
        @(negedge clk); stp = 1'b0; n += int'(busy);
      end
      while (busy) begin
        @(negedge clk);
        if (busy) n++;
      end
      check("R7 busy length", n, CYC);
      if (inject) begin
        check("R8 address frozen", int'(caddr), int'(a0));
        check("R8 read data frozen", int'(rdata), int'(d0));
      end
    end else begin
      check({quiet_tag, " no write cycle"}, int'(busy), 0);
      @(negedge clk);
      check({quiet_tag, " still idle"}, int'(busy), 0);
    end
    smask = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R7 actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", int'(busy), 0);
    check("R1 address after reset", int'(caddr), 0);
    check("R1 read data after reset", int'(rdata), 0);

    // Fill every page with a full 16-byte burst (R4 wrap, R7, R8).
    for (int p = 0; p < 32; p++) begin
      do_ld(p * 16);
      for (int i = 0; i < 16; i++) do_wr(pat(p * 16 + i));
      do_stop(p % 4 == 0, "R10");
    end

    // Whole-array sweep with wrap past the last word (R3).
    do_ld(0);
    for (int i = 0; i < NWORDS + 2; i++) do_rd("R3");
    do_stop(1'b0, "R10");

    // Partial page: only three entries change (R5).
    do_ld(83);
    for (int i = 0; i < 3; i++) do_wr(8'(8'hA1 + i));
    do_stop(1'b0, "R10");
    do_ld(80);
    for (int i = 0; i < 16; i++) do_rd("R5");

    // Twenty bytes into one page: later bytes win (R6).
    do_ld(158);
    for (int i = 0; i < 20; i++) do_wr(8'(8'h40 + i));
    do_stop(1'b0, "R10");
    do_ld(144);
    for (int i = 0; i < 16; i++) do_rd("R6");

    // Write protect discards data (R9).
    wp = 1'b1;
    do_ld(200);
    for (int i = 0; i < 4; i++) do_wr(8'(8'hC0 + i));
    do_stop(1'b0, "R9");
    wp = 1'b0;
    do_stop(1'b0, "R9");
    do_ld(200);
    for (int i = 0; i < 4; i++) do_rd("R9");

    // Address-only transaction starts nothing (R10).
    do_ld(300);
    do_stop(1'b0, "R10");

    // Current-address reads continue after a write (R11).
    do_ld(16 * 12 + 5);
    for (int i = 0; i < 3; i++) do_wr(8'(8'h70 + i));
    do_stop(1'b0, "R10");
    check("R11 held address", int'(caddr), 16 * 12 + 8);
    for (int i = 0; i < 3; i++) do_rd("R11");
    do_ld(16 * 3 + 14);
    for (int i = 0; i < 3; i++) do_wr(8'(8'h90 + i));
    do_stop(1'b0, "R10");
    check("R11 held wrapped address", int'(caddr), 16 * 3 + 1);
    do_rd("R11");
    maddr = 16 * 3 + 13;
    do_ld(16 * 3 + 13);
    for (int i = 0; i < 4; i++) do_rd("R11");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule